// File: doc/BRIEF.md
# Keyed Register Write Guard

This block sits between a register write/read port and a peripheral's configuration registers. A write to an ordinary register goes straight through to the register file on the same cycle through the `cfg_we` strobe, with address and data forwarded. When the guard is armed, writes whose offset is on a parameter list of guarded registers are discarded, and each discarded write is recorded as a violation with the low eight bits of the offending offset.

The guard owns two registers of its own. The mode register holds a single arm bit, and that bit can be changed only by a write that also carries a fixed 24-bit key in its upper bits. A wrong key leaves the arm bit alone and is not counted as a violation. The status register reports the violation flag and the captured source offset. Reading it clears both. Separate read and write addresses let a status read and a blocked write land in the same cycle; the new violation then wins.

Top module: `reg_write_guard`

## Requirements
- R1: After reset the guard is disarmed, `viol_flag` and `viol_src` are zero, and both guard registers read as zero.
- R2: A write to the mode offset (default 0x0E4) whose bits 31:8 equal 0x515350 loads bit 0 into `prot_on`, visible on the next cycle; 1 arms, 0 disarms.
- R3: A write to the mode offset with any other value in bits 31:8 leaves `prot_on` unchanged and does not set the violation flag.
- R4: A read of the mode offset returns `prot_on` in bit 0 and zero in bits 31:1, so the key field always reads as zero.
- R5: `wr_guarded` is high, combinationally, exactly when `wr_addr` equals an entry of the guarded-offset list (default 0x004, 0x020, 0x038, 0x1A0).
- R6: While disarmed, a write to any offset other than the two guard offsets raises `cfg_we` in the same cycle.
- R7: While armed, a write to a guarded offset keeps `cfg_we` low, and a write to an unguarded offset still raises it.
- R8: A blocked write sets `viol_flag` on the next cycle and captures `wr_addr[7:0]` into `viol_src`, a later blocked write replacing the source; the status read returns the flag in bit 0 and the source in bits 15:8, all other bits zero.
- R9: A read of the status offset (default 0x0E8) returns the current status and clears flag and source after that cycle, unless a write is blocked in the same cycle, in which case the new violation is kept.
- R10: Writes to either guard offset never raise `cfg_we`, and a write to the status offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 32 | Read data of the guard registers, zero for other offsets |
| cfg_we | output | 1 | Write enable to the configuration registers |
| cfg_addr | output | ADDR_W | Offset forwarded to the configuration registers |
| cfg_wdata | output | 32 | Data forwarded to the configuration registers |
| wr_guarded | output | 1 | Current write offset is on the guarded list |
| prot_on | output | 1 | Guard armed |
| viol_flag | output | 1 | A blocked write has been recorded |
| viol_src | output | 8 | Low byte of the offset of the latest blocked write |

## Verification
The properties assume that the strobes and addresses are stable and known at each rising edge and that the guard's own offsets are not on the guarded list, so a mode or status write is never counted as blocked. The bench changes inputs only on falling edges, keeps the default list, which is disjoint from the two guard offsets, and uses the separate read and write addresses only in the one test that aims a status read and a blocked write at the same cycle.

// File: rtl/reg_guard_pkg.sv
package reg_guard_pkg;

  localparam int          REG_W      = 32;
  localparam int          KEY_W      = 24;
  localparam int          VIOL_SRC_W = 8;
  localparam logic [KEY_W-1:0] GUARD_KEY = 24'h515350;

  // True when the upper field of a mode write carries the unlock key.
  function automatic logic key_matches(input logic [KEY_W-1:0] key_field);
    return key_field == GUARD_KEY;
  endfunction

  // Mode register image: arm bit at 0, key field reads as zero.
  function automatic logic [REG_W-1:0] pack_mode(input logic armed);
    return {{(REG_W-1){1'b0}}, armed};
  endfunction

  // Status register image: flag at bit 0, source at bits 15:8.
  function automatic logic [REG_W-1:0] pack_status(input logic flag,
                                                   input logic [VIOL_SRC_W-1:0] src);
    return {{(REG_W-16){1'b0}}, src, 7'b0, flag};
  endfunction

endpackage

// File: rtl/guard_match.sv
module guard_match #(
  parameter int ADDR_W = 12,
  parameter int N_PROT = 4,
  parameter logic [N_PROT*ADDR_W-1:0] PROT_LIST = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic [N_PROT-1:0] hit_vec;

  for (genvar i = 0; i < N_PROT; i++) begin : g_cmp
    assign hit_vec[i] = (addr == PROT_LIST[i*ADDR_W +: ADDR_W]);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/guard_mode.sv
module guard_mode
  import reg_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [KEY_W-1:0] key_in,
  input  logic             arm_in,
  output logic             armed,
  output logic             key_accept
);

  assign key_accept = mode_wr && key_matches(key_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (key_accept) armed <= arm_in;
  end

endmodule

// File: rtl/guard_status.sv
module guard_status #(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blocked,
  input  logic [SRC_W-1:0] src_in,
  input  logic             clr,
  output logic             flag,
  output logic [SRC_W-1:0] src
);

  // A new violation outranks a clearing read in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      src  <= '0;
    end else if (blocked) begin
      flag <= 1'b1;
      src  <= src_in;
    end else if (clr) begin
      flag <= 1'b0;
      src  <= '0;
    end
  end

endmodule

// File: rtl/reg_write_guard.sv
module reg_write_guard
  import reg_guard_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_PROT = 4,
  parameter logic [N_PROT*ADDR_W-1:0] PROT_LIST = {12'h1A0, 12'h038, 12'h020, 12'h004},
  parameter logic [ADDR_W-1:0] MODE_OFS = 12'h0E4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h0E8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [REG_W-1:0]      rd_data,
  output logic                  cfg_we,
  output logic [ADDR_W-1:0]     cfg_addr,
  output logic [REG_W-1:0]      cfg_wdata,
  output logic                  wr_guarded,
  output logic                  prot_on,
  output logic                  viol_flag,
  output logic [VIOL_SRC_W-1:0] viol_src
);

  // Named internal events, also watched by the checker.
  logic mode_wr;
  logic stat_wr;
  logic own_wr;
  logic wr_blocked;
  logic stat_rd;
  logic key_accept;

  assign mode_wr    = wr_en && (wr_addr == MODE_OFS);
  assign stat_wr    = wr_en && (wr_addr == STAT_OFS);
  assign own_wr     = mode_wr || stat_wr;
  assign stat_rd    = rd_en && (rd_addr == STAT_OFS);
  assign wr_blocked = wr_en && prot_on && wr_guarded && !own_wr;

  guard_match #(
    .ADDR_W   (ADDR_W),
    .N_PROT   (N_PROT),
    .PROT_LIST(PROT_LIST)
  ) u_match (
    .addr(wr_addr),
    .hit (wr_guarded)
  );

  guard_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .key_in    (wr_data[REG_W-1 -: KEY_W]),
    .arm_in    (wr_data[0]),
    .armed     (prot_on),
    .key_accept(key_accept)
  );

  guard_status #(.SRC_W(VIOL_SRC_W)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .blocked(wr_blocked),
    .src_in (wr_addr[VIOL_SRC_W-1:0]),
    .clr    (stat_rd),
    .flag   (viol_flag),
    .src    (viol_src)
  );

  assign cfg_we    = wr_en && !own_wr && !wr_blocked;
  assign cfg_addr  = wr_addr;
  assign cfg_wdata = wr_data;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (rd_addr == MODE_OFS)      rd_data = pack_mode(prot_on);
      else if (rd_addr == STAT_OFS) rd_data = pack_status(viol_flag, viol_src);
    end
  end

endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MODE_OFS = 12'h0E4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h0E8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              cfg_we,
  input logic              wr_guarded,
  input logic              prot_on,
  input logic              viol_flag,
  input logic [7:0]        viol_src,
  input logic              wr_blocked
);

  logic key_wr;
  logic stat_rd;
  assign key_wr  = wr_en && (wr_addr == MODE_OFS) && (wr_data[31:8] == 24'h515350);
  assign stat_rd = rd_en && (rd_addr == STAT_OFS);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(prot_on));

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> prot_on == $past(wr_data[0]));

  // R4
  key_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == MODE_OFS) |-> rd_data[31:1] == 31'b0);

  // R7
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && wr_en && wr_guarded) |-> !cfg_we);

  // R8
  viol_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> viol_flag && viol_src == $past(wr_addr[7:0]));

  // R9
  viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !wr_blocked) |=> !viol_flag && viol_src == 8'h00);

  // R3
  viol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_blocked && !stat_rd) |=> $stable(viol_flag) && $stable(viol_src));

  // R10
  own_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == MODE_OFS || wr_addr == STAT_OFS)) |-> !cfg_we);

endmodule

bind reg_write_guard guard_chk #(
  .ADDR_W  (ADDR_W),
  .MODE_OFS(MODE_OFS),
  .STAT_OFS(STAT_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .cfg_we    (cfg_we),
  .wr_guarded(wr_guarded),
  .prot_on   (prot_on),
  .viol_flag (viol_flag),
  .viol_src  (viol_src),
  .wr_blocked(wr_blocked)
);

// File: tb/reg_write_guard_tb.sv
module reg_write_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        cfg_we;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic        wr_guarded;
  logic        prot_on;
  logic        viol_flag;
  logic [7:0]  viol_src;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  reg_write_guard u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .wr_guarded(wr_guarded), .prot_on(prot_on),
    .viol_flag(viol_flag), .viol_src(viol_src)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        we;      // expected cfg_we this cycle
    logic        grd;     // expected wr_guarded
    logic [31:0] rdata;   // expected rd_data
    logic        prot;    // expected prot_on before the edge
    logic        vf;      // expected viol_flag before the edge
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 12'h004, 32'h0000_1234, 1'b1, 1'b1, 32'h0,    1'b0, 1'b0, 4'd6},  // R6 guarded but disarmed
    '{1'b1, 1'b0, 12'h010, 32'h0000_00AA, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 4'd6},  // R6
    '{1'b0, 1'b1, 12'h0E4, 32'h0,         1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b0, 12'h0E4, 32'h1234_5601, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 4'd3},  // R3 wrong key
    '{1'b0, 1'b1, 12'h0E8, 32'h0,         1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 4'd3},  // R3 no violation
    '{1'b1, 1'b0, 12'h0E4, 32'h5153_5001, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 4'd2},  // R2 arm
    '{1'b0, 1'b1, 12'h0E4, 32'h0,         1'b0, 1'b0, 32'h1,    1'b1, 1'b0, 4'd4},  // R4 key reads zero
    '{1'b1, 1'b0, 12'h020, 32'hDEAD_0001, 1'b0, 1'b1, 32'h0,    1'b1, 1'b0, 4'd7},  // R7 blocked
    '{1'b1, 1'b0, 12'h010, 32'h0000_0055, 1'b1, 1'b0, 32'h0,    1'b1, 1'b1, 4'd7},  // R7 passes
    '{1'b0, 1'b1, 12'h0E8, 32'h0,         1'b0, 1'b0, 32'h2001, 1'b1, 1'b1, 4'd8},  // R8
    '{1'b0, 1'b1, 12'h0E8, 32'h0,         1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 4'd9},  // R9 cleared
    '{1'b1, 1'b0, 12'h1A0, 32'h0000_0001, 1'b0, 1'b1, 32'h0,    1'b1, 1'b0, 4'd7},  // R7
    '{1'b1, 1'b0, 12'h038, 32'h0000_0002, 1'b0, 1'b1, 32'h0,    1'b1, 1'b1, 4'd8},  // R8
    '{1'b0, 1'b1, 12'h0E8, 32'h0,         1'b0, 1'b0, 32'h3801, 1'b1, 1'b1, 4'd8},  // R8 latest wins
    '{1'b1, 1'b0, 12'h0E8, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 4'd10}, // R10
    '{1'b0, 1'b1, 12'h0E8, 32'h0,         1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 4'd10}, // R10 unchanged
    '{1'b1, 1'b0, 12'h0E4, 32'h5153_5000, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 4'd2},  // R2 disarm
    '{1'b1, 1'b0, 12'h038, 32'h0000_0007, 1'b1, 1'b1, 32'h0,    1'b0, 1'b0, 4'd2}   // R2 disarmed now
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [11:0] wa, input logic [31:0] wd,
                       input logic r, input logic [11:0] ra);
    @(negedge clk);
    wr_en = w; wr_addr = wa; wr_data = wd;
    rd_en = r; rd_addr = ra;
    #2;
  endtask

  task automatic idle();
    drive(1'b0, 12'h000, 32'h0, 1'b0, 12'h000);
  endtask

  function automatic logic in_list(input logic [11:0] a);
    case (a)
      12'h004, 12'h020, 12'h038, 12'h1A0: return 1'b1;
      default:                             return 1'b0;
    endcase
  endfunction

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    drive(1'b0, 12'h000, 32'h0, 1'b1, 12'h0E8);
    chk(rd_data == 32'h0, "R1 status", rd_data, 32'h0);
    chk({prot_on, viol_flag, viol_src} == 10'h0, "R1 state",
        {22'h0, prot_on, viol_flag, viol_src}, 32'h0);
    drive(1'b0, 12'h000, 32'h0, 1'b1, 12'h0E4);
    chk(rd_data == 32'h0, "R1 mode", rd_data, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].rd, VECS[i].addr);
      chk(cfg_we == VECS[i].we, $sformatf("R%0d cfg_we step %0d", VECS[i].req, i),
          {31'h0, cfg_we}, {31'h0, VECS[i].we});
      chk(wr_guarded == VECS[i].grd, $sformatf("R5 guarded step %0d", i),
          {31'h0, wr_guarded}, {31'h0, VECS[i].grd});
      chk(rd_data == VECS[i].rdata, $sformatf("R%0d rd_data step %0d", VECS[i].req, i),
          rd_data, VECS[i].rdata);
      chk(prot_on == VECS[i].prot && viol_flag == VECS[i].vf,
          $sformatf("R%0d state step %0d", VECS[i].req, i),
          {30'h0, prot_on, viol_flag}, {30'h0, VECS[i].prot, VECS[i].vf});
      if (cfg_we)
        chk(cfg_addr == VECS[i].addr && cfg_wdata == VECS[i].wdata,
            "R6 forward", {20'h0, cfg_addr}, {20'h0, VECS[i].addr});
    end

    // R3: wrong key while armed cannot disarm and records nothing
    drive(1'b1, 12'h0E4, 32'h5153_5001, 1'b0, 12'h000);
    drive(1'b1, 12'h0E4, 32'h5153_5100, 1'b0, 12'h000);
    idle();
    chk(prot_on == 1'b1, "R3 stays armed", {31'h0, prot_on}, 32'h1);
    chk(viol_flag == 1'b0, "R3 no violation", {31'h0, viol_flag}, 32'h0);

    // R8: source keeps only low byte of the offset
    drive(1'b1, 12'h1A0, 32'h0, 1'b0, 12'h000);
    // R9: status read and blocked write in the same cycle
    drive(1'b1, 12'h020, 32'h0, 1'b1, 12'h0E8);
    chk(rd_data == 32'h0000_A001, "R8 low byte source", rd_data, 32'h0000_A001);
    idle();
    chk(viol_flag == 1'b1 && viol_src == 8'h20, "R9 new violation kept",
        {23'h0, viol_flag, viol_src}, {23'h0, 1'b1, 8'h20});
    drive(1'b0, 12'h000, 32'h0, 1'b1, 12'h0E8);
    chk(rd_data == 32'h0000_2001, "R9 status after overlap", rd_data, 32'h0000_2001);
    idle();
    chk(viol_flag == 1'b0 && viol_src == 8'h00, "R9 cleared",
        {23'h0, viol_flag, viol_src}, 32'h0);

    // R5: full sweep of the write offset
    begin
      int mism = 0;
      for (int a = 0; a < 4096; a++) begin
        wr_addr = a[11:0];
        #1;
        if (wr_guarded != in_list(a[11:0])) mism++;
      end
      chk(mism == 0, "R5 sweep", mism, 32'h0);
    end

    // R1: reset while armed with a pending violation
    drive(1'b1, 12'h004, 32'h0, 1'b0, 12'h000);
    idle();
    rst_n = 1'b0;
    #1;
    chk(prot_on == 1'b0 && viol_flag == 1'b0 && viol_src == 8'h0, "R1 re-reset",
        {22'h0, prot_on, viol_flag, viol_src}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();

    done = 1'b1;
    report();
  end

endmodule